// File: doc/BRIEF.md
# Indexed-Access Real-Time Clock Register File

This block holds a 64-byte clock register space behind a two-port host window. The host first writes an index port to select one of the 64 locations, then reads or writes that location through a data port. Locations 0 to 9 hold the time, calendar and alarm values: seconds, minutes and hours each with an alarm byte beside it, then day of week, date, month and year. The year is at location 9. A control byte at location 0x0B carries a freeze bit (bit 7) and a number-format bit (bit 2). Format bit 1 means plain binary and 0 means BCD.

A one-cycle seconds tick advances the clock in the selected format. While the freeze bit is set, the tick is ignored, so software can load a consistent time. The block also watches the host for misuse of this access protocol. It raises four sticky flags: a data access without a fresh index, a time write while not frozen, a format change outside a freeze window, and a format change whose freeze window closed before all ten time bytes were rewritten.

Top module: `rtcx_regfile`

## Requirements
- R1: After reset, violFlags is 0, the control byte reads 0x00, and seconds, minutes, hours, the three alarm bytes and the year read 0x00. Day of week, date and month read 0x01.
- R2: An index-port write keeps only bits 5:0 of the written value. A data-port read returns the selected byte on hostRdData in the cycle after the read strobe and holds it until the next read. A data-port write stores the byte at the selected location.
- R3: An index is consumed by one data access. A data access without a fresh index sets violFlags bit 0. Such a write is ignored, and such a read returns 0x00.
- R4: With the freeze bit at 0 and the format bit at 0 (BCD), each tick advances seconds. Rollovers carry in this chain: seconds 59 to 0 into minutes, minutes 59 to 0 into hours, hours 23 to 0 into day of week (7 to 1) and date, date 30 to 1 into month, month 12 to 1 into year, and year 99 to 0.
- R5: With format bit 2 of the control byte at 1, the same rollover chain runs on plain binary values.
- R6: While freeze bit 7 of the control byte is 1, ticks change no time byte, and a value written to a time byte reads back unchanged.
- R7: A data write to locations 0 to 9 while the freeze bit is 0 sets violFlags bit 1 and is still stored. When such a write falls in the same cycle as a tick, the written byte takes the written value and the other bytes advance.
- R8: A control write that changes the format bit while the freeze bit is 0 both before and after the write sets violFlags bit 2. The write is still applied.
- R9: If the format bit changed in a freeze window (including the write that opened it), and the write that clears the freeze bit comes before all ten time bytes were written inside that window, violFlags bit 3 is set.
- R10: Violation flags stay set until reset.
- R11: Ticks never change the alarm bytes at locations 1, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe; ignored when hostWr is also 1 |
| hostSel | input | 1 | 0 selects the index port, 1 selects the data port |
| hostWrData | input | 8 | Host write value |
| secTick | input | 1 | One-cycle seconds tick |
| hostRdData | output | 8 | Registered read value |
| violFlags | output | 4 | Sticky flags: bit0 index, bit1 unfrozen time write, bit2 format change, bit3 incomplete reload |

## Verification
A host data write and a seconds tick can land on the clock bytes in the same cycle. The bench provokes this by driving a minutes write together with secTick while the clock is not frozen. Afterwards it reads back the minutes and seconds: minutes must hold the written value and seconds must have moved by one. In the same case it checks that the unfrozen-write flag rose.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;
  parameter int LOC_AW    = 6;
  parameter int NUM_TIME  = 10;
  parameter int CTRL_IDX  = 11;
  parameter int FREEZE_BIT = 7;
  parameter int FMT_BIT   = 2;
  parameter int NUM_FLAGS = 4;

  localparam int SEC_IDX  = 0;
  localparam int SECA_IDX = 1;
  localparam int MIN_IDX  = 2;
  localparam int MINA_IDX = 3;
  localparam int HR_IDX   = 4;
  localparam int HRA_IDX  = 5;
  localparam int DOW_IDX  = 6;
  localparam int DATE_IDX = 7;
  localparam int MON_IDX  = 8;
  localparam int YR_IDX   = 9;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic              rdBad;
    logic [LOC_AW-1:0] addr;
    logic [7:0]        wdata;
  } accessStrobe_t;

  function automatic logic [7:0] bcdToBin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic [7:0] binToBcd(input logic [7:0] n);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = n / 8'd10;
    ones = n % 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  // returns {carry, next value} for one clock field
  function automatic logic [8:0] bumpField(input logic [7:0] v, input logic [7:0] lo,
                                           input logic [7:0] hi, input logic binMode);
    logic [7:0] b;
    logic [7:0] n;
    logic       c;
    b = binMode ? v : bcdToBin(v);
    if (b >= hi) begin
      n = lo;
      c = 1'b1;
    end else begin
      n = b + 8'd1;
      c = 1'b0;
    end
    return {c, (binMode ? n : binToBcd(n))};
  endfunction
endpackage

// File: rtl/rtcx_ctrl.sv
module rtcx_ctrl
  import rtcx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWr,
  input  logic                 hostRd,
  input  logic                 hostSel,
  input  logic [7:0]           hostWrData,
  input  logic [7:0]           ctrlByte,
  output accessStrobe_t        strobe,
  output logic [NUM_FLAGS-1:0] violFlags
);
  logic [LOC_AW-1:0]   idxReg;
  logic                idxValid;
  logic                dmChanged;
  logic [NUM_TIME-1:0] wrMask;

  logic dataWr, dataRd, isTime, isCtrl, oldSet, newSet, dmDiff;

  always_comb begin
    dataWr = hostWr & hostSel;
    dataRd = hostRd & ~hostWr & hostSel;
    strobe.wrEn  = dataWr & idxValid;
    strobe.rdEn  = dataRd & idxValid;
    strobe.rdBad = dataRd & ~idxValid;
    strobe.addr  = idxReg;
    strobe.wdata = hostWrData;
    isTime = (32'(idxReg) < NUM_TIME);
    isCtrl = (32'(idxReg) == CTRL_IDX);
    oldSet = ctrlByte[FREEZE_BIT];
    newSet = hostWrData[FREEZE_BIT];
    dmDiff = hostWrData[FMT_BIT] ^ ctrlByte[FMT_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg    <= '0;
      idxValid  <= 1'b0;
      dmChanged <= 1'b0;
      wrMask    <= '0;
      violFlags <= '0;
    end else begin
      if (hostWr && !hostSel) begin
        idxReg   <= hostWrData[LOC_AW-1:0];
        idxValid <= 1'b1;
      end else if (dataWr || dataRd) begin
        idxValid <= 1'b0;
        if (!idxValid) violFlags[0] <= 1'b1;
      end
      if (strobe.wrEn && isTime) begin
        if (!oldSet) violFlags[1] <= 1'b1;
        else begin
          for (int i = 0; i < NUM_TIME; i++)
            if (32'(idxReg) == i) wrMask[i] <= 1'b1;
        end
      end
      if (strobe.wrEn && isCtrl) begin
        if (!oldSet && !newSet && dmDiff) violFlags[2] <= 1'b1;
        if (!oldSet && newSet) begin
          dmChanged <= dmDiff;
          wrMask    <= '0;
        end else if (oldSet && newSet) begin
          dmChanged <= dmChanged | dmDiff;
        end else if (oldSet && !newSet) begin
          if ((dmChanged || dmDiff) && !(&wrMask)) violFlags[3] <= 1'b1;
          dmChanged <= 1'b0;
        end
      end
    end
  end

  AST_INDEX_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn || strobe.rdEn) |=> !(strobe.wrEn || strobe.rdEn)); // R3
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((violFlags & $past(violFlags)) == $past(violFlags))); // R10
endmodule

// File: rtl/rtcx_store.sv
module rtcx_store
  import rtcx_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          secTick,
  input  accessStrobe_t strobe,
  output logic [7:0]    ctrlByte,
  output logic [7:0]    rdData
);
  localparam int NUM_LOC = 1 << LOC_AW;

  logic [7:0] mem [NUM_LOC];
  logic       binMode, frozen, tickEn;
  logic [8:0] rSec, rMin, rHr, rDow, rDate, rMon, rYr;
  logic       advMin, advHr, advDay, advMon, advYr;

  always_comb begin
    ctrlByte = mem[CTRL_IDX];
    binMode  = ctrlByte[FMT_BIT];
    frozen   = ctrlByte[FREEZE_BIT];
    tickEn   = secTick & ~frozen;
    rSec  = bumpField(mem[SEC_IDX],  8'd0, 8'd59, binMode);
    rMin  = bumpField(mem[MIN_IDX],  8'd0, 8'd59, binMode);
    rHr   = bumpField(mem[HR_IDX],   8'd0, 8'd23, binMode);
    rDow  = bumpField(mem[DOW_IDX],  8'd1, 8'd7,  binMode);
    rDate = bumpField(mem[DATE_IDX], 8'd1, 8'd30, binMode);
    rMon  = bumpField(mem[MON_IDX],  8'd1, 8'd12, binMode);
    rYr   = bumpField(mem[YR_IDX],   8'd0, 8'd99, binMode);
    advMin = rSec[8];
    advHr  = advMin & rMin[8];
    advDay = advHr & rHr[8];
    advMon = advDay & rDate[8];
    advYr  = advMon & rMon[8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LOC; i++) mem[i] <= 8'h00;
      mem[DOW_IDX]  <= 8'h01;
      mem[DATE_IDX] <= 8'h01;
      mem[MON_IDX]  <= 8'h01;
      rdData <= 8'h00;
    end else begin
      if (tickEn) begin
        mem[SEC_IDX] <= rSec[7:0];
        if (advMin) mem[MIN_IDX] <= rMin[7:0];
        if (advHr)  mem[HR_IDX]  <= rHr[7:0];
        if (advDay) begin
          mem[DOW_IDX]  <= rDow[7:0];
          mem[DATE_IDX] <= rDate[7:0];
        end
        if (advMon) mem[MON_IDX] <= rMon[7:0];
        if (advYr)  mem[YR_IDX]  <= rYr[7:0];
      end
      // host write wins over the tick for the same byte
      if (strobe.wrEn) mem[strobe.addr] <= strobe.wdata;
      if (strobe.rdEn) rdData <= mem[strobe.addr];
      else if (strobe.rdBad) rdData <= 8'h00;
    end
  end

  AST_FREEZE_SEC: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !(strobe.wrEn && strobe.addr == LOC_AW'(SEC_IDX)))
      |=> mem[SEC_IDX] == $past(mem[SEC_IDX])); // R6
  AST_FREEZE_YEAR: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !(strobe.wrEn && strobe.addr == LOC_AW'(YR_IDX)))
      |=> mem[YR_IDX] == $past(mem[YR_IDX])); // R6
  AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.addr == LOC_AW'(SECA_IDX))
      |=> mem[SECA_IDX] == $past(mem[SECA_IDX])); // R11
  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (binMode && mem[SEC_IDX] < 8'd60 && !strobe.wrEn) |=> mem[SEC_IDX] < 8'd60); // R5
endmodule

// File: rtl/rtcx_regfile.sv
module rtcx_regfile
  import rtcx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWr,
  input  logic                 hostRd,
  input  logic                 hostSel,
  input  logic [7:0]           hostWrData,
  input  logic                 secTick,
  output logic [7:0]           hostRdData,
  output logic [NUM_FLAGS-1:0] violFlags
);
  accessStrobe_t strobe;
  logic [7:0]    ctrlByte;

  rtcx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostSel(hostSel),
    .hostWrData(hostWrData), .ctrlByte(ctrlByte), .strobe(strobe), .violFlags(violFlags)
  );

  rtcx_store store_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .strobe(strobe),
    .ctrlByte(ctrlByte), .rdData(hostRdData)
  );
endmodule

// File: tb/rtcx_regfile_tb_top.sv
`timescale 1ns/1ps
module rtcx_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0, hostRd = 1'b0, hostSel = 1'b0, secTick = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic [7:0] hostRdData;
  logic [3:0] violFlags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic rdSeen = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  rtcx_regfile dut_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostSel(hostSel),
    .hostWrData(hostWrData), .secTick(secTick), .hostRdData(hostRdData), .violFlags(violFlags)
  );

  task automatic checkEq(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed data read
  always @(posedge clk) rdSeen <= hostRd & hostSel & ~hostWr;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) checkEq(hostRdData, 8'hxx, "R2 unexpected read");
      else checkEq(hostRdData, expQ.pop_front(), tagQ.pop_front());
    end
  end

  task automatic drive(input logic wr, input logic rd, input logic sel,
                       input logic [7:0] d, input logic tk);
    hostWr = wr; hostRd = rd; hostSel = sel; hostWrData = d; secTick = tk;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0; hostSel = 1'b0; hostWrData = 8'h00; secTick = 1'b0;
  endtask

  task automatic wrLoc(input logic [7:0] a, input logic [7:0] d);
    drive(1, 0, 0, a, 0);
    drive(1, 0, 1, d, 0);
  endtask

  task automatic rdRaw(input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    drive(0, 1, 1, 8'h00, 0);
  endtask

  task automatic rdLoc(input logic [7:0] a, input logic [7:0] exp, input string tag);
    drive(1, 0, 0, a, 0);
    rdRaw(exp, tag);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq({4'd0, violFlags}, 8'h00, "R1 flags after reset");
    rdLoc(8'h00, 8'h00, "R1 seconds reset");
    rdLoc(8'h07, 8'h01, "R1 date reset");
    rdLoc(8'h09, 8'h00, "R1 year reset");
    rdLoc(8'h0B, 8'h00, "R1 control reset");

    // R6 freeze, load BCD time
    wrLoc(8'h0B, 8'h80);
    wrLoc(8'h00, 8'h59); wrLoc(8'h02, 8'h59); wrLoc(8'h04, 8'h23);
    wrLoc(8'h06, 8'h07); wrLoc(8'h07, 8'h30); wrLoc(8'h08, 8'h12);
    wrLoc(8'h09, 8'h99); wrLoc(8'h01, 8'h11); wrLoc(8'h03, 8'h22);
    wrLoc(8'h05, 8'h33);
    ticks(3);
    rdLoc(8'h00, 8'h59, "R6 seconds frozen");
    rdLoc(8'h09, 8'h99, "R6 year written reads back");
    wrLoc(8'h0B, 8'h00);
    checkEq({4'd0, violFlags}, 8'h00, "R9 no flag when format unchanged");

    // R4 full BCD rollover
    ticks(1);
    rdLoc(8'h00, 8'h00, "R4 seconds roll");
    rdLoc(8'h02, 8'h00, "R4 minutes roll");
    rdLoc(8'h04, 8'h00, "R4 hours roll");
    rdLoc(8'h06, 8'h01, "R4 day of week roll");
    rdLoc(8'h07, 8'h01, "R4 date roll");
    rdLoc(8'h08, 8'h01, "R4 month roll");
    rdLoc(8'h09, 8'h00, "R4 year roll");
    rdLoc(8'h01, 8'h11, "R11 alarm seconds held");
    rdLoc(8'h03, 8'h22, "R11 alarm minutes held");
    rdLoc(8'h05, 8'h33, "R11 alarm hours held");
    ticks(10);
    rdLoc(8'h00, 8'h10, "R4 BCD digit carry");

    // R5 binary mode, legal format change in freeze window
    wrLoc(8'h0B, 8'h84);
    wrLoc(8'h00, 8'd58); wrLoc(8'h02, 8'd59); wrLoc(8'h04, 8'd23);
    wrLoc(8'h06, 8'd3);  wrLoc(8'h07, 8'd30); wrLoc(8'h08, 8'd5);
    wrLoc(8'h09, 8'd7);  wrLoc(8'h01, 8'd0);  wrLoc(8'h03, 8'd0);
    wrLoc(8'h05, 8'd0);
    wrLoc(8'h0B, 8'h04);
    checkEq({4'd0, violFlags}, 8'h00, "R9 complete reload no flag");
    ticks(2);
    rdLoc(8'h00, 8'd0, "R5 binary seconds");
    rdLoc(8'h02, 8'd0, "R5 binary minutes");
    rdLoc(8'h04, 8'd0, "R5 binary hours");
    rdLoc(8'h06, 8'd4, "R5 binary day of week");
    rdLoc(8'h07, 8'd1, "R5 binary date");
    rdLoc(8'h08, 8'd6, "R5 binary month");
    rdLoc(8'h09, 8'd7, "R5 binary year");

    // R3 index protocol; R2 index truncation
    wrLoc(8'h20, 8'hAA);
    drive(1, 0, 1, 8'h55, 0);
    checkEq({4'd0, violFlags}, 8'h01, "R3 flag on stale data write");
    rdLoc(8'h20, 8'hAA, "R3 stale write ignored");
    rdRaw(8'h00, "R3 stale read gives zero");
    wrLoc(8'h4C, 8'h5A);
    rdLoc(8'h0C, 8'h5A, "R2 index keeps six bits");

    // R7 write and tick in the same cycle, unfrozen
    drive(1, 0, 0, 8'h02, 0);
    drive(1, 0, 1, 8'h2A, 1);
    checkEq({4'd0, violFlags}, 8'h03, "R7 unfrozen write flag");
    rdLoc(8'h02, 8'h2A, "R7 written minutes win");
    rdLoc(8'h00, 8'd1, "R7 seconds still advance");

    // R8 illegal format change
    wrLoc(8'h0B, 8'h00);
    checkEq({4'd0, violFlags}, 8'h07, "R8 format change flag");
    rdLoc(8'h0B, 8'h00, "R8 control write applied");

    // R9 incomplete reload
    wrLoc(8'h0B, 8'h84);
    wrLoc(8'h00, 8'd5);
    wrLoc(8'h0B, 8'h04);
    checkEq({4'd0, violFlags}, 8'h0F, "R9 incomplete reload flag");

    // R10 sticky
    wrLoc(8'h0B, 8'h84);
    ticks(4);
    checkEq({4'd0, violFlags}, 8'h0F, "R10 flags remain set");
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq({4'd0, violFlags}, 8'h00, "R10 flags cleared by reset");

    repeat (2) @(negedge clk);
    checkEq(8'(expQ.size()), 8'h00, "R2 all reads answered");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule